// File: doc/BRIEF.md
# Serial Min-Sum Check Node Unit with Zigzag Forward Passing

This block is one check-node processing element of a partly parallel decoder for irregular repeat-accumulate LDPC codes. It takes soft messages in log-likelihood form, at most one per clock. A last flag closes each check node. Once a node is closed, the unit plays back one extrinsic message per incident edge, one per clock and in the order the edges arrived. Check node updates use the min-sum rule.

Consecutive check nodes in a chain are linked by degree-2 parity nodes in a zigzag pattern. When a node closes, the unit adds the right-hand parity node's channel LLR to the extrinsic message it sends toward that parity node. The saturated sum is held in an internal register and used as the left parity input of the next check node in the same pass, so it is never written to memory. The only parity-related result leaving the unit is the backward message toward the left parity node, and it is presented once per node for storage. The feeding logic streams each node's information edges and ends with the right parity edge, which is the one flagged last.

Top module: `chk_node_unit`

## Requirements
- R1: While reset is asserted, and after its release until a node has been closed, outValid, outLast and bwdValid are low.
- R2: An input edge is taken only in a cycle with inValid high. In other cycles inMsg, inLast, chainStart and chanLlr have no effect. chainStart is sampled only with the first edge of a node, and chanLlr only with the edge flagged last.
- R3: Messages are 6-bit two's complement with the sign in bit 5. An input of -32 counts as magnitude 31. No extrinsic or backward output ever equals -32.
- R4: The extrinsic output for edge i has a magnitude equal to the smallest magnitude among all other stream edges of the node plus its forward input. Its sign is the XOR of the sign bits of those same other inputs, and its value is formed as sign ? -magnitude : +magnitude.
- R5: A node has 1 to 32 edges. When the last edge is sampled at clock edge T, the output for edge i appears after clock edge T+i. The outputs come on consecutive cycles, and outLast marks the final one.
- R6: bwdValid pulses for one cycle after the clock edge that takes a last edge. bwdMsg then carries the min-sum result of the node's stream edges alone, leaving out the forward input.
- R7: The forward input of a node that does not start a chain equals the previous node's extrinsic output for its last edge plus the chanLlr sampled with that edge, saturated to the range -32..31.
- R8: A node whose first edge comes with chainStart high uses a forward input of +31.
- R9: When several inputs share the smallest magnitude, every edge of the node gets that smallest magnitude.
- R10: Nodes of equal degree may follow one another with no idle cycles. Each node's outputs then overlap the intake of the next node, and all results stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies an input edge this cycle |
| inMsg | input | 6 | Incoming message for the edge |
| inLast | input | 1 | Edge is the last one of the node (the right parity edge) |
| chainStart | input | 1 | With the first edge: the node begins a zigzag chain |
| chanLlr | input | 6 | With the last edge: channel LLR of the right parity node |
| outValid | output | 1 | Extrinsic output valid |
| outMsg | output | 6 | Extrinsic message, in input edge order |
| outLast | output | 1 | Final extrinsic output of the node |
| bwdValid | output | 1 | Backward parity message valid |
| bwdMsg | output | 6 | Backward message toward the left parity node |

## Verification
For each node, the bench computes the expected outputs when it drives the node. It stamps each one with the cycle it is due: the backward message one cycle after the clock edge that took the last edge, and the output for edge i i+1 cycles after that edge. A falling-edge monitor compares every output against its cycle stamp. An early, late, missing or unexpected output is counted as a failure under R5 or R6. The bench carries the forward value from node to node in its own model, so the R7 chaining is checked through the next node's outputs.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  // Strobes from the control to the datapath for the current cycle.
  typedef struct packed {
    logic absorb;  // an edge is taken this cycle
    logic first;   // that edge opens a node
    logic close;   // that edge closes the node
  } cnuStrobe_t;
endpackage

// File: rtl/cnu_ctrl.sv
module cnu_ctrl
  import cnu_pkg::*;
#(
  parameter int MAX_DEG = 32,
  localparam int CW = $clog2(MAX_DEG + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inLast,
  output cnuStrobe_t    stb,
  output logic [CW-1:0] edgeIdx,
  output logic [CW-1:0] outPtr,
  output logic          outValid,
  output logic          outLast
);
  logic [CW-1:0] inCnt;
  logic [CW-1:0] outLen;
  logic          outBusy;

  always_comb begin
    stb.absorb = inValid;
    stb.first  = inValid && (inCnt == '0);
    stb.close  = inValid && inLast;
  end

  assign edgeIdx  = inCnt;
  assign outValid = outBusy;
  assign outLast  = outBusy && (outPtr == (outLen - CW'(1)));

  // Input side: position of the next edge inside the current node.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (stb.close) begin
      inCnt <= '0;
    end else if (stb.absorb) begin
      inCnt <= inCnt + CW'(1);
    end
  end

  // Output side: a node that closes reloads the playback, even in the
  // cycle where the previous playback ends.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBusy <= 1'b0;
      outLen  <= '0;
      outPtr  <= '0;
    end else if (stb.close) begin
      outBusy <= 1'b1;
      outLen  <= inCnt + CW'(1);
      outPtr  <= '0;
    end else if (outBusy) begin
      if (outPtr == (outLen - CW'(1))) begin
        outBusy <= 1'b0;
      end else begin
        outPtr <= outPtr + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cnu_dpath.sv
module cnu_dpath
  import cnu_pkg::*;
#(
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 32,
  localparam int CW = $clog2(MAX_DEG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnuStrobe_t       stb,
  input  logic [MSG_W-1:0] inMsg,
  input  logic             chainStart,
  input  logic [MSG_W-1:0] chanLlr,
  input  logic [CW-1:0]    edgeIdx,
  input  logic [CW-1:0]    outPtr,
  output logic [MSG_W-1:0] outMsg,
  output logic             bwdValid,
  output logic [MSG_W-1:0] bwdMsg
);
  localparam int MAG_W = MSG_W - 1;
  localparam int SLOTS = 1 << CW;
  localparam logic [MAG_W-1:0] MAGMAX  = '1;
  localparam logic [CW-1:0]    FWD_TAG = CW'(MAX_DEG);

  function automatic logic [MAG_W-1:0] magOf(input logic [MSG_W-1:0] v);
    logic [MSG_W-1:0] neg;
    neg = -v;
    if (!v[MSG_W-1])              return v[MAG_W-1:0];
    else if (v[MAG_W-1:0] == '0)  return MAGMAX;
    else                          return neg[MAG_W-1:0];
  endfunction

  function automatic logic [MSG_W-1:0] makeMsg(input logic sgn, input logic [MAG_W-1:0] mag);
    logic [MSG_W-1:0] pos;
    pos = {1'b0, mag};
    return sgn ? -pos : pos;
  endfunction

  function automatic logic [MSG_W-1:0] satAdd(input logic [MSG_W-1:0] a, input logic [MSG_W-1:0] b);
    logic [MSG_W:0] sum;
    sum = {a[MSG_W-1], a} + {b[MSG_W-1], b};
    if (sum[MSG_W] != sum[MSG_W-1]) return sum[MSG_W] ? {1'b1, {MAG_W{1'b0}}} : {1'b0, MAGMAX};
    return sum[MSG_W-1:0];
  endfunction

  // Running state of the node being taken in.
  logic [MAG_W-1:0] accMin1, accMin2, strMin;
  logic [CW-1:0]    accIdx;
  logic             accSign, strSign;
  logic [SLOTS-1:0] signVec;
  // Closed node being played back.
  logic [MAG_W-1:0] pbMin1, pbMin2;
  logic [CW-1:0]    pbIdx;
  logic             pbSign;
  logic [SLOTS-1:0] pbSigns;
  // Forward message carried along the zigzag chain.
  logic [MSG_W-1:0] fwdReg;

  logic [MSG_W-1:0] fwdIn;
  logic [MAG_W-1:0] bMin1, bMin2, bStrMin, edgeMag;
  logic [CW-1:0]    bIdx;
  logic             bSign, bStrSign, edgeSign;
  logic [MAG_W-1:0] nMin1, nMin2, nStrMin, lastMag, pbMag;
  logic [CW-1:0]    nIdx;
  logic             nSign, nStrSign;
  logic [MSG_W-1:0] lastExt, fwdNext;
  logic [SLOTS-1:0] signNext;

  always_comb begin
    fwdIn    = chainStart ? {1'b0, MAGMAX} : fwdReg;
    edgeMag  = magOf(inMsg);
    edgeSign = inMsg[MSG_W-1];
    if (stb.first) begin
      bMin1    = magOf(fwdIn);
      bMin2    = MAGMAX;
      bIdx     = FWD_TAG;
      bSign    = fwdIn[MSG_W-1];
      bStrMin  = MAGMAX;
      bStrSign = 1'b0;
    end else begin
      bMin1    = accMin1;
      bMin2    = accMin2;
      bIdx     = accIdx;
      bSign    = accSign;
      bStrMin  = strMin;
      bStrSign = strSign;
    end
    nMin1 = bMin1;
    nMin2 = bMin2;
    nIdx  = bIdx;
    if (edgeMag < bMin1) begin
      nMin2 = bMin1;
      nMin1 = edgeMag;
      nIdx  = edgeIdx;
    end else if (edgeMag < bMin2) begin
      nMin2 = edgeMag;
    end
    nSign    = bSign ^ edgeSign;
    nStrMin  = (edgeMag < bStrMin) ? edgeMag : bStrMin;
    nStrSign = bStrSign ^ edgeSign;
    // Extrinsic toward the right parity node, i.e. for the closing edge.
    lastMag = (nIdx == edgeIdx) ? nMin2 : nMin1;
    lastExt = makeMsg(nSign ^ edgeSign, lastMag);
    fwdNext = satAdd(lastExt, chanLlr);
    // Playback of the closed node.
    pbMag  = (outPtr == pbIdx) ? pbMin2 : pbMin1;
    outMsg = makeMsg(pbSign ^ pbSigns[outPtr], pbMag);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_sign
    assign signNext[g] = (stb.absorb && (edgeIdx == CW'(g))) ? edgeSign : signVec[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accMin1  <= '0;
      accMin2  <= '0;
      accIdx   <= '0;
      accSign  <= 1'b0;
      strMin   <= '0;
      strSign  <= 1'b0;
      signVec  <= '0;
      pbMin1   <= '0;
      pbMin2   <= '0;
      pbIdx    <= '0;
      pbSign   <= 1'b0;
      pbSigns  <= '0;
      fwdReg   <= '0;
      bwdValid <= 1'b0;
      bwdMsg   <= '0;
    end else begin
      bwdValid <= stb.close;
      if (stb.absorb) begin
        accMin1 <= nMin1;
        accMin2 <= nMin2;
        accIdx  <= nIdx;
        accSign <= nSign;
        strMin  <= nStrMin;
        strSign <= nStrSign;
        signVec <= signNext;
      end
      if (stb.close) begin
        pbMin1  <= nMin1;
        pbMin2  <= nMin2;
        pbIdx   <= nIdx;
        pbSign  <= nSign;
        pbSigns <= signNext;
        fwdReg  <= fwdNext;
        bwdMsg  <= makeMsg(nStrSign, nStrMin);
      end
    end
  end
endmodule

// File: rtl/chk_node_unit.sv
module chk_node_unit
  import cnu_pkg::*;
#(
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [MSG_W-1:0] inMsg,
  input  logic             inLast,
  input  logic             chainStart,
  input  logic [MSG_W-1:0] chanLlr,
  output logic             outValid,
  output logic [MSG_W-1:0] outMsg,
  output logic             outLast,
  output logic             bwdValid,
  output logic [MSG_W-1:0] bwdMsg
);
  localparam int CW = $clog2(MAX_DEG + 1);

  cnuStrobe_t    stb;
  logic [CW-1:0] edgeIdx;
  logic [CW-1:0] outPtr;

  cnu_ctrl #(.MAX_DEG(MAX_DEG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .stb(stb), .edgeIdx(edgeIdx), .outPtr(outPtr),
    .outValid(outValid), .outLast(outLast)
  );

  cnu_dpath #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inMsg(inMsg),
    .chainStart(chainStart), .chanLlr(chanLlr), .edgeIdx(edgeIdx),
    .outPtr(outPtr), .outMsg(outMsg), .bwdValid(bwdValid), .bwdMsg(bwdMsg)
  );
endmodule

// File: rtl/cnu_checker.sv
module cnu_checker #(
  parameter int MSG_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inLast,
  input logic             outValid,
  input logic             outLast,
  input logic [MSG_W-1:0] outMsg,
  input logic             bwdValid,
  input logic [MSG_W-1:0] bwdMsg
);
  localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {(MSG_W-1){1'b0}}};

  AST_BWD_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inLast |=> bwdValid); // R6
  AST_BWD_ONLY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    bwdValid |-> $past(inValid && inLast)); // R6
  AST_OUT_STARTS_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inLast)); // R5
  AST_OUT_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |=> outValid); // R5
  AST_OUT_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R5
  AST_OUT_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outMsg != MOST_NEG); // R3
  AST_BWD_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    bwdValid |-> bwdMsg != MOST_NEG); // R3
endmodule

bind chk_node_unit cnu_checker #(.MSG_W(MSG_W)) u_cnu_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
  .outValid(outValid), .outLast(outLast), .outMsg(outMsg),
  .bwdValid(bwdValid), .bwdMsg(bwdMsg)
);

// File: tb/chk_node_unit_bench.sv
module chk_node_unit_bench;
  localparam int MSG_W = 6;
  localparam int MAXD  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [MSG_W-1:0] inMsg = '0;
  logic inLast = 1'b0;
  logic chainStart = 1'b0;
  logic [MSG_W-1:0] chanLlr = '0;
  logic outValid, outLast, bwdValid;
  logic [MSG_W-1:0] outMsg, bwdMsg;

  chk_node_unit #(.MSG_W(MSG_W), .MAX_DEG(MAXD)) u_chk_node_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMsg(inMsg), .inLast(inLast),
    .chainStart(chainStart), .chanLlr(chanLlr), .outValid(outValid),
    .outMsg(outMsg), .outLast(outLast), .bwdValid(bwdValid), .bwdMsg(bwdMsg)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;
  int benchF = 31;

  int    qMsg[$];
  bit    qLast[$];
  int    qCyc[$];
  string qTag[$];
  int    bMsg[$];
  int    bCyc[$];
  string bTag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int magOf(input int v);
    if (v == -32) return 31;
    return (v < 0) ? -v : v;
  endfunction

  function automatic int clampMsg(input int v);
    if (v > 31) return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  // Expected min-sum results for one node.
  task automatic model(input int e[MAXD], input int n, input int f,
                       output int ext[MAXD], output int bwd);
    int m;
    bit s;
    for (int i = 0; i < MAXD; i++) ext[i] = 0;
    for (int i = 0; i < n; i++) begin
      m = magOf(f);
      s = (f < 0);
      for (int j = 0; j < n; j++) begin
        if (j != i) begin
          if (magOf(e[j]) < m) m = magOf(e[j]);
          s ^= (e[j] < 0);
        end
      end
      ext[i] = s ? -m : m;
    end
    m = 31;
    s = 1'b0;
    for (int j = 0; j < n; j++) begin
      if (magOf(e[j]) < m) m = magOf(e[j]);
      s ^= (e[j] < 0);
    end
    bwd = s ? -m : m;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      inValid    = 1'b0;
      inMsg      = MSG_W'($urandom);
      inLast     = 1'($urandom);
      chainStart = 1'($urandom);
      chanLlr    = MSG_W'($urandom);
    end
  endtask

  task automatic runNode(input int e[MAXD], input int n, input int chan,
                         input bit start, input int gapMax, input string tag);
    int ext[MAXD];
    int bwd;
    int f;
    int c;
    f = start ? 31 : benchF;
    model(e, n, f, ext, bwd);
    for (int i = 0; i < n; i++) begin
      if (gapMax > 0) idle($urandom_range(gapMax));
      @(negedge clk);
      inValid    = 1'b1;
      inMsg      = MSG_W'(e[i]);
      inLast     = (i == n - 1);
      chainStart = (i == 0) ? start : 1'($urandom);
      chanLlr    = (i == n - 1) ? MSG_W'(chan) : MSG_W'($urandom);
      if (i == n - 1) begin
        c = cyc;
        for (int k = 0; k < n; k++) begin
          qMsg.push_back(ext[k]);
          qLast.push_back(k == n - 1);
          qCyc.push_back(c + 1 + k);
          qTag.push_back(tag);
        end
        bMsg.push_back(bwd);
        bCyc.push_back(c + 1);
        bTag.push_back(tag);
      end
    end
    benchF = clampMsg(ext[n - 1] + chan);
  endtask

  // Falling-edge monitor: every result is due in a known cycle.
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (qMsg.size() == 0) begin
          check(1'b0, "R5 unexpected output", $signed(outMsg), 0);
        end else begin
          check($signed(outMsg) == qMsg[0], qTag[0], $signed(outMsg), qMsg[0]);
          check(qCyc[0] == cyc, "R5 output cycle", cyc, qCyc[0]);
          check(outLast == qLast[0], "R5 outLast", outLast, qLast[0]);
          void'(qMsg.pop_front()); void'(qLast.pop_front());
          void'(qCyc.pop_front()); void'(qTag.pop_front());
        end
      end else if (qCyc.size() > 0 && qCyc[0] <= cyc) begin
        check(1'b0, "R5 missing output", 0, qMsg[0]);
        void'(qMsg.pop_front()); void'(qLast.pop_front());
        void'(qCyc.pop_front()); void'(qTag.pop_front());
      end
      if (bwdValid) begin
        if (bMsg.size() == 0) begin
          check(1'b0, "R6 unexpected backward", $signed(bwdMsg), 0);
        end else begin
          check($signed(bwdMsg) == bMsg[0], {bTag[0], " R6 backward"}, $signed(bwdMsg), bMsg[0]);
          check(bCyc[0] == cyc, "R6 backward cycle", cyc, bCyc[0]);
          void'(bMsg.pop_front()); void'(bCyc.pop_front()); void'(bTag.pop_front());
        end
      end else if (bCyc.size() > 0 && bCyc[0] <= cyc) begin
        check(1'b0, "R6 missing backward", 0, bMsg[0]);
        void'(bMsg.pop_front()); void'(bCyc.pop_front()); void'(bTag.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int e[MAXD];
    int n;
    int len;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAXD; i++) e[i] = 0;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(!outValid && !outLast, "R1 outputs in reset", outValid, 0);
    check(!bwdValid, "R1 backward in reset", bwdValid, 0);
    rstN = 1'b1;
    idle(3);
    check(!outValid && !outLast, "R1 outputs after reset", outValid, 0);
    check(!bwdValid, "R1 backward after reset", bwdValid, 0);
    monOn = 1'b1;

    // R8 / R4: chain start, all positive edges
    e[0] = 5; e[1] = 10; e[2] = 3; e[3] = 7;
    runNode(e, 4, 2, 1'b1, 0, "R8");
    // R7: forward input taken from the node above, mixed signs, -32 edge (R3)
    e[0] = -20; e[1] = 15; e[2] = -32; e[3] = 25;
    runNode(e, 4, -9, 1'b0, 0, "R7");
    // R4: small magnitudes against the carried forward value
    e[0] = 1; e[1] = -2; e[2] = 0; e[3] = -1;
    runNode(e, 4, 31, 1'b0, 0, "R4");
    // R3: forward sum saturates positive, then all-most-negative node
    e[0] = 30; e[1] = 31; e[2] = 29; e[3] = 31;
    runNode(e, 4, 31, 1'b0, 0, "R3");
    e[0] = -32; e[1] = -32; e[2] = -32; e[3] = -32;
    runNode(e, 4, -32, 1'b0, 0, "R3");
    e[0] = -3; e[1] = 8; e[2] = 6; e[3] = -31;
    runNode(e, 4, -32, 1'b0, 0, "R7");
    idle(6);
    // R9: ties on the smallest magnitude
    e[0] = -4; e[1] = 4; e[2] = 9;
    runNode(e, 3, 0, 1'b1, 0, "R9");
    e[0] = 6; e[1] = -6; e[2] = 6;
    runNode(e, 3, 0, 1'b0, 0, "R9");
    idle(5);
    // R2: idle cycles with junk inside a node
    e[0] = 12; e[1] = -7; e[2] = 18; e[3] = -25; e[4] = 9;
    runNode(e, 5, 4, 1'b1, 3, "R2");
    runNode(e, 5, -6, 1'b0, 3, "R2");
    idle(8);
    // R5: single-edge node and largest node
    e[0] = -13;
    runNode(e, 1, 5, 1'b1, 0, "R5");
    runNode(e, 1, 5, 1'b0, 0, "R5");
    idle(4);
    for (int i = 0; i < MAXD; i++) e[i] = int'($urandom_range(63)) - 32;
    runNode(e, MAXD, 7, 1'b1, 0, "R5");
    runNode(e, MAXD, -3, 1'b0, 0, "R5");
    idle(MAXD + 4);

    // R10: random chains, back to back within a chain
    for (int c = 0; c < 40; c++) begin
      n = $urandom_range(12, 2);
      len = $urandom_range(8, 3);
      for (int k = 0; k < len; k++) begin
        for (int i = 0; i < n; i++) begin
          e[i] = ($urandom_range(7) == 0) ? -32 : int'($urandom_range(63)) - 32;
        end
        runNode(e, n, int'($urandom_range(63)) - 32, k == 0,
                ($urandom_range(3) == 0) ? 2 : 0, "R10");
      end
      idle(n + 3);
    end

    idle(40);
    check(qMsg.size() == 0, "R5 outputs outstanding", qMsg.size(), 0);
    check(bMsg.size() == 0, "R6 backward outstanding", bMsg.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule